// File: doc/BRIEF.md
# Partitioned Dot-Product Class Search

This block holds C binary class prototypes of D bits each and classifies a D-bit query by picking the prototype with the highest dot-product similarity. The similarity of a class is the number of bit positions that are 1 in both the query and that class's prototype. The score is built up over F steps. Each step takes one D/F-bit slice of the query and compares it with the matching slice of every prototype. All slices of the prototypes go through the same column arrangement.

Inside every partition the class slices sit in scrambled column positions. A small table maps each column position to its class. The same table serves every partition, is loaded at configuration time, and sends each column's partial score to the class it belongs to. Software first fills the table, then writes each prototype slice by class number and slice index. After that it presents queries one at a time. Each accepted query produces a single-cycle result pulse that carries the index of the winning class.

Top module: `class_search`

## Requirements
- R1: The score of a class is the count of bit positions where both the query and that class's prototype are 1. A query bit of 0 adds nothing, whatever the prototype bit is.
- R2: Slice p of a vector is bits [p*D/F +: D/F]. Writing a prototype slice to index p only affects the comparison with query slice p. Slice indices of F or above are ignored.
- R3: Column table write (`perm_we`) sets column `perm_pos` to class `perm_cls`. A prototype write for class k stores into the column whose table entry is k. During a search, the score of column j is added to the class in table entry j. Reloading the table without rewriting prototypes therefore moves the stored data to the newly named classes.
- R4: All class sums are cleared when a query is accepted, so a result never depends on an earlier query.
- R5: The result is the class with the largest sum. When sums are equal, the lowest class index wins. The result is always below C.
- R6: `pred_valid` is high for exactly one cycle. It rises F+1 clock edges after the edge that accepts the query.
- R7: A `q_valid` that arrives while a search is in progress is ignored: no second result is produced, and the running result is unchanged.
- R8: After reset, `pred_valid` and `pred_class` are 0 and the column table is the identity (column j holds class j).
- R9: An all-zero query gives every class a sum of 0, so the result is class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| perm_we | input | 1 | Write enable for the column-to-class table |
| perm_pos | input | $clog2(C) | Column position to write |
| perm_cls | input | $clog2(C) | Class index stored for that column |
| proto_we | input | 1 | Prototype slice write enable |
| proto_cls | input | $clog2(C) | Class of the slice being written |
| proto_seg | input | $clog2(F) | Slice index of the write |
| proto_data | input | D/F | Slice data |
| q_valid | input | 1 | Query present; accepted only when idle |
| q_data | input | D | Full query vector |
| pred_valid | output | 1 | One-cycle result strobe |
| pred_class | output | $clog2(C) | Winning class index |

## Verification
Some properties are checked on every cycle: the result strobe is a single-cycle pulse, and it arrives a fixed F+1 edges after acceptance. The reported class holds a sum at least as large as every other class and strictly larger than every lower-indexed class. The sums are zero right after a query is accepted, and the captured query does not change while a search runs. Other behaviour can only be shown by the bench's scenarios, because it depends on what was stored. This covers the exact sums that come from the stored prototypes, slice placement, the routing of scrambled columns back to their classes, and what happens when the table is reloaded over existing data. It also covers ignoring a query that arrives while busy, and tie-breaking on identical prototypes.

// File: rtl/class_search_pkg.sv
package class_search_pkg;

    // Default configuration used when the block is elaborated alone.
    localparam int DEF_DIM     = 80;
    localparam int DEF_PARTS   = 10;
    localparam int DEF_CLASSES = 6;

    // Control sequence of one search.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_PICK  = 2'd2
    } srch_state_e;

endpackage

// File: rtl/col_class_table.sv
module col_class_table #(
    parameter int C  = 6,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] cls,
    input  logic [CW-1:0] find_cls,
    output logic [CW-1:0] class_of_col [C],
    output logic [CW-1:0] col_of_find
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < C; k++) class_of_col[k] <= CW'(k);
        end else if (we && (int'(pos) < C)) begin
            class_of_col[pos] <= cls;
        end
    end

    // Reverse lookup: column that currently carries find_cls.
    always_comb begin
        col_of_find = '0;
        for (int k = C - 1; k >= 0; k--) begin
            if (class_of_col[k] == find_cls) col_of_find = CW'(k);
        end
    end

endmodule

// File: rtl/seg_dot.sv
module seg_dot #(
    parameter int SEG = 8,
    parameter int C   = 6,
    parameter int SW  = 4
) (
    input  logic [SEG-1:0] q_seg,
    input  logic [SEG-1:0] cols  [C],
    output logic [SW-1:0]  score [C]
);

    for (genvar g = 0; g < C; g++) begin : g_col
        logic [SEG-1:0] both;
        assign both = q_seg & cols[g];
        always_comb begin
            score[g] = '0;
            for (int b = 0; b < SEG; b++) score[g] = score[g] + SW'(both[b]);
        end
    end

endmodule

// File: rtl/wta_pick.sv
module wta_pick #(
    parameter int C  = 6,
    parameter int CW = 3,
    parameter int TW = 7
) (
    input  logic [TW-1:0] sums [C],
    output logic [CW-1:0] win
);

    logic [TW-1:0] best;

    // Strict comparison in ascending order keeps the lowest index on ties.
    always_comb begin
        win  = '0;
        best = sums[0];
        for (int k = 1; k < C; k++) begin
            if (sums[k] > best) begin
                best = sums[k];
                win  = CW'(k);
            end
        end
    end

endmodule

// File: rtl/class_search.sv
module class_search
    import class_search_pkg::*;
#(
    parameter int D = DEF_DIM,
    parameter int F = DEF_PARTS,
    parameter int C = DEF_CLASSES,
    localparam int SEG = D / F,
    localparam int CW  = (C > 1) ? $clog2(C) : 1,
    localparam int PW  = (F > 1) ? $clog2(F) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           perm_we,
    input  logic [CW-1:0]  perm_pos,
    input  logic [CW-1:0]  perm_cls,
    input  logic           proto_we,
    input  logic [CW-1:0]  proto_cls,
    input  logic [PW-1:0]  proto_seg,
    input  logic [SEG-1:0] proto_data,
    input  logic           q_valid,
    input  logic [D-1:0]   q_data,
    output logic           pred_valid,
    output logic [CW-1:0]  pred_class
);

    localparam int TW = $clog2(D + 1);
    localparam int SW = $clog2(SEG + 1);

    srch_state_e    state;
    logic [PW-1:0]  step;
    logic [D-1:0]   qreg;
    logic [TW-1:0]  sums     [C];
    logic [TW-1:0]  sums_nxt [C];
    logic [SEG-1:0] store    [F][C];
    logic [SEG-1:0] cur_cols [C];
    logic [SW-1:0]  score    [C];
    logic [CW-1:0]  class_of_col [C];
    logic [CW-1:0]  wr_col;
    logic [CW-1:0]  win;

    col_class_table #(.C(C), .CW(CW)) u_table (
        .clk          (clk),
        .rst          (rst),
        .we           (perm_we),
        .pos          (perm_pos),
        .cls          (perm_cls),
        .find_cls     (proto_cls),
        .class_of_col (class_of_col),
        .col_of_find  (wr_col)
    );

    // Prototype slice storage, laid out by partition and physical column.
    always_ff @(posedge clk) begin
        if (proto_we && (int'(proto_seg) < F)) store[proto_seg][wr_col] <= proto_data;
    end

    always_comb begin
        for (int k = 0; k < C; k++) cur_cols[k] = store[step][k];
    end

    seg_dot #(.SEG(SEG), .C(C), .SW(SW)) u_dot (
        .q_seg (qreg[int'(step)*SEG +: SEG]),
        .cols  (cur_cols),
        .score (score)
    );

    // Route each column's partial score back to its true class.
    always_comb begin
        for (int k = 0; k < C; k++) sums_nxt[k] = sums[k];
        for (int k = 0; k < C; k++) begin
            sums_nxt[class_of_col[k]] = sums_nxt[class_of_col[k]] + TW'(score[k]);
        end
    end

    wta_pick #(.C(C), .CW(CW), .TW(TW)) u_wta (
        .sums (sums),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            step       <= '0;
            qreg       <= '0;
            pred_valid <= 1'b0;
            pred_class <= '0;
            for (int k = 0; k < C; k++) sums[k] <= '0;
        end else begin
            pred_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (q_valid) begin
                        qreg  <= q_data;
                        step  <= '0;
                        state <= ST_ACCUM;
                        for (int k = 0; k < C; k++) sums[k] <= '0;
                    end
                end
                ST_ACCUM: begin
                    for (int k = 0; k < C; k++) sums[k] <= sums_nxt[k];
                    if (step == PW'(F - 1)) state <= ST_PICK;
                    else                    step  <= step + 1'b1;
                end
                ST_PICK: begin
                    pred_class <= win;
                    pred_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/class_search_chk.sv
module class_search_chk
    import class_search_pkg::*;
#(
    parameter int D = DEF_DIM,
    parameter int F = DEF_PARTS,
    parameter int C = DEF_CLASSES,
    localparam int CW = (C > 1) ? $clog2(C) : 1,
    localparam int TW = $clog2(D + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          q_valid,
    input srch_state_e   st,
    input logic [D-1:0]  qreg,
    input logic [TW-1:0] sums [C],
    input logic          pred_valid,
    input logic [CW-1:0] pred_class
);

    logic [15:0] lat;
    logic        win_ok;
    logic        all_zero;

    // Edges since the last accepted query (saturating).
    always_ff @(posedge clk) begin
        if (rst)                          lat <= '1;
        else if (st == ST_IDLE && q_valid) lat <= '0;
        else if (lat != '1)               lat <= lat + 1'b1;
    end

    always_comb begin
        win_ok   = (int'(pred_class) < C);
        all_zero = 1'b1;
        for (int k = 0; k < C; k++) begin
            if (sums[k] != '0) all_zero = 1'b0;
            if (int'(pred_class) < C) begin
                if (sums[k] > sums[pred_class]) win_ok = 1'b0;
                if (k < int'(pred_class) && sums[k] == sums[pred_class]) win_ok = 1'b0;
            end
        end
    end

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        pred_valid |=> !pred_valid);

    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> (lat == 16'(F + 1)));

    p_range_r5: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> (int'(pred_class) < C));

    p_best_class_r5: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> win_ok);

    p_clear_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && q_valid) |=> all_zero);

    p_busy_query_held_r7: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(qreg));

endmodule

bind class_search class_search_chk #(.D(D), .F(F), .C(C)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .q_valid    (q_valid),
    .st         (state),
    .qreg       (qreg),
    .sums       (sums),
    .pred_valid (pred_valid),
    .pred_class (pred_class)
);

// File: tb/class_search_bench.sv
module class_search_bench;

    localparam int D   = 80;
    localparam int F   = 10;
    localparam int C   = 6;
    localparam int SEG = D / F;
    localparam int CW  = $clog2(C);
    localparam int PW  = $clog2(F);
    localparam int NQ  = 7;

    localparam logic [D-1:0] QTAB [NQ] = '{
        80'h0000_0000_0000_0000_0000,
        80'hFFFF_FFFF_FFFF_FFFF_FFFF,
        80'hA5A5_5A5A_0F0F_F0F0_3C3C,
        80'h1234_5678_9ABC_DEF0_1357,
        80'hFF00_0000_0000_0000_0000,
        80'h0000_0000_0000_0000_00FF,
        80'h8421_8421_8421_8421_8421
    };

    logic           clk = 1'b0;
    logic           rst;
    logic           perm_we;
    logic [CW-1:0]  perm_pos;
    logic [CW-1:0]  perm_cls;
    logic           proto_we;
    logic [CW-1:0]  proto_cls;
    logic [PW-1:0]  proto_seg;
    logic [SEG-1:0] proto_data;
    logic           q_valid;
    logic [D-1:0]   q_data;
    logic           pred_valid;
    logic [CW-1:0]  pred_class;

    int n_checks = 0;
    int n_fail   = 0;
    logic [D-1:0] model_p [C];

    always #10 clk = ~clk;

    class_search #(.D(D), .F(F), .C(C)) u_class_search (
        .clk(clk), .rst(rst), .perm_we(perm_we), .perm_pos(perm_pos), .perm_cls(perm_cls),
        .proto_we(proto_we), .proto_cls(proto_cls), .proto_seg(proto_seg), .proto_data(proto_data),
        .q_valid(q_valid), .q_data(q_data), .pred_valid(pred_valid), .pred_class(pred_class)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [D-1:0] mk_proto(input int c);
        logic [D-1:0] v;
        for (int i = 0; i < D; i++) v[i] = (((i * (c + 3)) + c * c) % 7) < 3;
        return v;
    endfunction

    function automatic int dotp(input logic [D-1:0] a, input logic [D-1:0] b);
        int n = 0;
        for (int i = 0; i < D; i++) n += int'(a[i] & b[i]);
        return n;
    endfunction

    function automatic int expect_class(input logic [D-1:0] q);
        int best = 0;
        int bv = dotp(q, model_p[0]);
        for (int c = 1; c < C; c++) begin
            if (dotp(q, model_p[c]) > bv) begin
                bv = dotp(q, model_p[c]);
                best = c;
            end
        end
        return best;
    endfunction

    task automatic set_perm(input int pos, input int cls);
        @(negedge clk);
        perm_we = 1'b1; perm_pos = CW'(pos); perm_cls = CW'(cls);
        @(negedge clk);
        perm_we = 1'b0;
    endtask

    task automatic write_proto(input int cls, input logic [D-1:0] v);
        for (int s = 0; s < F; s++) begin
            @(negedge clk);
            proto_we = 1'b1; proto_cls = CW'(cls); proto_seg = PW'(s);
            proto_data = v[s*SEG +: SEG];
        end
        @(negedge clk);
        proto_we = 1'b0;
        model_p[cls] = v;
    endtask

    task automatic run_query(input logic [D-1:0] q, input string req);
        int lat = 0;
        int exp = expect_class(q);
        @(negedge clk);
        q_valid = 1'b1; q_data = q;
        @(negedge clk);
        q_valid = 1'b0;
        while (!pred_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        chk(int'(pred_class) == exp, req, int'(pred_class), exp);
        chk(lat == F + 1, "R6 latency", lat, F + 1);
        @(negedge clk);
        chk(!pred_valid, "R6 single pulse", int'(pred_valid), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [D-1:0] tmp;
        rst = 1'b1; perm_we = 1'b0; perm_pos = '0; perm_cls = '0;
        proto_we = 1'b0; proto_cls = '0; proto_seg = '0; proto_data = '0;
        q_valid = 1'b0; q_data = '0;
        repeat (3) @(negedge clk);
        chk(!pred_valid, "R8 reset valid", int'(pred_valid), 0);
        chk(pred_class == '0, "R8 reset class", int'(pred_class), 0);
        rst = 1'b0;

        // R8 identity table in use: prototypes written by class, then table walk.
        for (int c = 0; c < C; c++) write_proto(c, mk_proto(c));
        for (int i = 0; i < NQ; i++) run_query(QTAB[i], "R1 R2 R8 table");
        for (int c = 0; c < C; c++) run_query(mk_proto(c), "R1 R5 self query");

        // R9 all-zero query.
        run_query('0, "R9 zero query");

        // R3 scrambled columns: pos -> (5*pos+1) mod C, prototypes rewritten by class.
        for (int p = 0; p < C; p++) set_perm(p, (5 * p + 1) % C);
        for (int c = 0; c < C; c++) write_proto(c, mk_proto(c));
        for (int i = 0; i < NQ; i++) run_query(QTAB[i], "R3 scrambled table");
        for (int c = 0; c < C; c++) run_query(mk_proto(c), "R3 scrambled self");

        // R3 reload table without rewriting: columns 0 and 1 swap their classes.
        set_perm(0, 0);
        set_perm(1, 1);
        tmp = model_p[0]; model_p[0] = model_p[1]; model_p[1] = tmp;
        run_query(mk_proto(0), "R3 reload moves data");
        run_query(mk_proto(1), "R3 reload moves data");

        // R5 tie: two classes with identical all-ones prototypes, lowest wins.
        write_proto(4, '1);
        write_proto(2, '1);
        run_query(80'h0F0F_0000_0000_0000_0001, "R5 tie lowest");
        chk(pred_class == CW'(2), "R5 tie lowest index", int'(pred_class), 2);

        // R2 slice placement: only the last slice of class 5 set, query only there.
        for (int c = 0; c < C; c++) write_proto(c, '0);
        tmp = '0; tmp[(F-1)*SEG +: SEG] = '1;
        write_proto(5, tmp);
        run_query(tmp, "R2 last slice");
        chk(pred_class == CW'(5), "R2 last slice class", int'(pred_class), 5);
        // R1 query ones only where every prototype is 0: scores all 0 -> class 0.
        run_query(~tmp, "R1 zero overlap");
        // R2 out-of-range slice index ignored.
        @(negedge clk);
        proto_we = 1'b1; proto_cls = CW'(3); proto_seg = PW'(F + 2); proto_data = '1;
        @(negedge clk);
        proto_we = 1'b0;
        run_query(~tmp, "R2 bad slice ignored");

        // R4 sums cleared: strong query then weak query, result follows the second.
        write_proto(1, {D{1'b1}} >> (D/2));
        run_query(tmp, "R4 first");
        run_query(~tmp, "R4 second");

        // R7 query while busy is ignored.
        @(negedge clk);
        q_valid = 1'b1; q_data = tmp;
        @(negedge clk);
        q_data = ~tmp;
        @(negedge clk);
        q_valid = 1'b0;
        begin
            int waited = 0;
            while (!pred_valid && waited < 50) begin
                @(negedge clk);
                waited++;
            end
        end
        chk(pred_class == CW'(5), "R7 busy query ignored", int'(pred_class), 5);
        begin
            int extra = 0;
            for (int k = 0; k < F + 4; k++) begin
                @(negedge clk);
                if (pred_valid) extra++;
            end
            chk(extra == 0, "R7 no second result", extra, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule